// File: doc/BRIEF.md
# Carry-Aware Integer ALU

This block is the combinational execute stage of a small microcontroller core. Each cycle it takes a first source operand, a second source that is either a register value or a short zero-extended immediate, the carry bit the core holds, and a 5-bit operation code. It returns a data result, a new carry value and a strobe that tells the core whether to store that carry.

The operations are add, subtract and reverse subtract, each with and without carry-in. There are also logical shifts, bitwise logic, inversion, unsigned minimum and maximum, and single-bit clear and set. A last operation finds the highest bit of the first operand that equals a chosen bit value. The register file, the carry flip-flop, instruction decode and memory access are all outside the block.

Data width and immediate width are parameters. Their legal values are checked during elaboration.

Top module: `carry_alu`

## Requirements
- R1: When `imm_sel_i` is 1, the second operand is `imm_i` zero-extended to DATA_W. When it is 0, the second operand is `src_b_i`. Call this value B and call `src_a_i` A.
- R2: Op 0 (ADD) returns A+B. Op 1 (ADDC) returns A+B+`carry_i`. In both, `carry_o` is bit DATA_W of the sum taken at DATA_W+1 bits.
- R3: Op 2 (SUB) returns A-B. Op 3 (SUBC) returns A-B-`carry_i`. In both, `carry_o` is the borrow, which is 1 exactly when the true difference is negative.
- R4: Op 4 (RSUB) returns B-A. Op 5 (RSUBC) returns B-A-`carry_i`. `carry_o` is the borrow of that difference.
- R5: `carry_we_o` is 1 for ops 0 to 5 and 0 for every other code. Whenever `carry_we_o` is 0, `carry_o` equals `carry_i`.
- R6: Op 6 (SHL) shifts A left and op 7 (SHR) shifts A right, logically. The shift amount is the low log2(DATA_W) bits of B. Vacated bits are filled with zero.
- R7: Op 8 returns A&B, op 9 returns A|B and op 10 returns A^B. Op 11 (INV) returns ~A, and B has no effect on it.
- R8: Op 12 (MIN) returns the smaller of A and B and op 13 (MAX) returns the larger, both compared as unsigned numbers.
- R9: Op 14 (BCLR) returns A with bit k cleared and op 15 (BSET) returns A with bit k set. k is the low log2(DATA_W) bits of B.
- R10: Op 16 (SCAN) returns the highest index i for which A[i] equals B[0]. If no bit of A matches, it returns DATA_W.
- R11: Codes 17 to 31 return a zero result and leave `carry_we_o` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| src_a_i | input | DATA_W | First source operand A |
| src_b_i | input | DATA_W | Register form of the second operand |
| imm_i | input | IMM_W | Immediate form of the second operand |
| imm_sel_i | input | 1 | Selects the immediate as the second operand |
| carry_i | input | 1 | Stored carry bit |
| result_o | output | DATA_W | Data result |
| carry_o | output | 1 | New carry value |
| carry_we_o | output | 1 | Carry store enable |

## Verification
The bench builds the block with DATA_W=8 and IMM_W=4. At that size every value of A can be swept against a spread of register operands and against all sixteen immediates, under both carry inputs. The wrap of the extended-width carry and borrow, every shift amount and bit index, and the no-match return of the scan are therefore all reached without picking corner values by hand. Every unused operation code is driven with operand patterns, so a stray carry strobe or a nonzero result on those codes shows up at the ports.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [4:0] {
      OP_ADD   = 5'd0,
      OP_ADDC  = 5'd1,
      OP_SUB   = 5'd2,
      OP_SUBC  = 5'd3,
      OP_RSUB  = 5'd4,
      OP_RSUBC = 5'd5,
      OP_SHL   = 5'd6,
      OP_SHR   = 5'd7,
      OP_AND   = 5'd8,
      OP_OR    = 5'd9,
      OP_XOR   = 5'd10,
      OP_INV   = 5'd11,
      OP_MIN   = 5'd12,
      OP_MAX   = 5'd13,
      OP_BCLR  = 5'd14,
      OP_BSET  = 5'd15,
      OP_SCAN  = 5'd16
   } alu_op_e;

   localparam int unsigned OP_LAST_USED = 16;

endpackage

// File: rtl/alu_opnd_sel.sv
module alu_opnd_sel #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IMM_W  = 8
) (
   input  logic [DATA_W-1:0] reg_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic              imm_sel_i,
   output logic [DATA_W-1:0] opnd_o
);
   localparam int unsigned PAD_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] imm_ext;

   generate
      if (PAD_W == 0) begin : g_nopad
         assign imm_ext = imm_i;
      end else begin : g_pad
         assign imm_ext = {{PAD_W{1'b0}}, imm_i};
      end
   endgenerate

   assign opnd_o = imm_sel_i ? imm_ext : reg_i;
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0] lhs_i,
   input  logic [DATA_W-1:0] rhs_i,
   input  logic              sub_i,
   input  logic              use_cin_i,
   input  logic              cin_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              cout_o
);
   localparam int unsigned EXT_W = DATA_W + 1;

   logic [EXT_W-1:0] lhs_x, rhs_x, cin_x, ext;

   always_comb begin
      lhs_x = {1'b0, lhs_i};
      rhs_x = {1'b0, rhs_i};
      cin_x = {{DATA_W{1'b0}}, use_cin_i & cin_i};
      if (sub_i) ext = lhs_x - rhs_x - cin_x;
      else       ext = lhs_x + rhs_x + cin_x;
   end

   assign sum_o  = ext[DATA_W-1:0];
   assign cout_o = ext[DATA_W];
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
   import alu_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  alu_op_e           op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] res_o
);
   localparam int unsigned SH_W = $clog2(DATA_W);

   logic [SH_W-1:0]   sh;
   logic [DATA_W-1:0] onehot;

   assign sh     = b_i[SH_W-1:0];
   assign onehot = {{(DATA_W-1){1'b0}}, 1'b1} << sh;

   always_comb begin
      unique case (op_i)
         OP_SHL:  res_o = a_i << sh;
         OP_SHR:  res_o = a_i >> sh;
         OP_AND:  res_o = a_i & b_i;
         OP_OR:   res_o = a_i | b_i;
         OP_XOR:  res_o = a_i ^ b_i;
         OP_INV:  res_o = ~a_i;
         OP_MIN:  res_o = (a_i < b_i) ? a_i : b_i;
         OP_MAX:  res_o = (a_i > b_i) ? a_i : b_i;
         OP_BCLR: res_o = a_i & ~onehot;
         OP_BSET: res_o = a_i | onehot;
         default: res_o = '0;
      endcase
   end
endmodule

// File: rtl/alu_lead_scan.sv
module alu_lead_scan #(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned IDX_W = $clog2(DATA_W + 1)
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic              want_i,
   output logic [IDX_W-1:0]  idx_o
);
   logic [DATA_W-1:0] hit;

   generate
      for (genvar g = 0; g < DATA_W; g++) begin : g_hit
         assign hit[g] = ~(a_i[g] ^ want_i);
      end
   endgenerate

   always_comb begin
      idx_o = IDX_W'(DATA_W);
      for (int i = 0; i < DATA_W; i++) begin
         if (hit[i]) idx_o = IDX_W'(i);
      end
   end
endmodule

// File: rtl/carry_alu.sv
module carry_alu
   import alu_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IMM_W  = 8
) (
   input  logic [4:0]        op_i,
   input  logic [DATA_W-1:0] src_a_i,
   input  logic [DATA_W-1:0] src_b_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic              imm_sel_i,
   input  logic              carry_i,
   output logic [DATA_W-1:0] result_o,
   output logic              carry_o,
   output logic              carry_we_o
);
   localparam int unsigned IDX_W = $clog2(DATA_W + 1);

   generate
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("carry_alu: DATA_W must be a power of two of at least 8");
      end
      if (IMM_W < 1 || IMM_W > DATA_W) begin : g_bad_imm
         $error("carry_alu: IMM_W must lie between 1 and DATA_W");
      end
   endgenerate

   alu_op_e           op;
   logic [DATA_W-1:0] opnd_b, lhs, rhs, sum, logic_res;
   logic [IDX_W-1:0]  scan_idx;
   logic              is_arith, is_sub, is_rev, use_cin, cout;

   assign op = alu_op_e'(op_i);

   alu_opnd_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
      .reg_i     (src_b_i),
      .imm_i     (imm_i),
      .imm_sel_i (imm_sel_i),
      .opnd_o    (opnd_b)
   );

   always_comb begin
      is_arith = 1'b0;
      is_sub   = 1'b0;
      is_rev   = 1'b0;
      use_cin  = 1'b0;
      unique case (op)
         OP_ADD:   is_arith = 1'b1;
         OP_ADDC:  begin is_arith = 1'b1; use_cin = 1'b1; end
         OP_SUB:   begin is_arith = 1'b1; is_sub = 1'b1; end
         OP_SUBC:  begin is_arith = 1'b1; is_sub = 1'b1; use_cin = 1'b1; end
         OP_RSUB:  begin is_arith = 1'b1; is_sub = 1'b1; is_rev = 1'b1; end
         OP_RSUBC: begin is_arith = 1'b1; is_sub = 1'b1; is_rev = 1'b1; use_cin = 1'b1; end
         default:  ;
      endcase
   end

   assign lhs = is_rev ? opnd_b  : src_a_i;
   assign rhs = is_rev ? src_a_i : opnd_b;

   alu_addsub #(.DATA_W(DATA_W)) u_addsub (
      .lhs_i     (lhs),
      .rhs_i     (rhs),
      .sub_i     (is_sub),
      .use_cin_i (use_cin),
      .cin_i     (carry_i),
      .sum_o     (sum),
      .cout_o    (cout)
   );

   alu_bitops #(.DATA_W(DATA_W)) u_bitops (
      .op_i  (op),
      .a_i   (src_a_i),
      .b_i   (opnd_b),
      .res_o (logic_res)
   );

   alu_lead_scan #(.DATA_W(DATA_W)) u_scan (
      .a_i    (src_a_i),
      .want_i (opnd_b[0]),
      .idx_o  (scan_idx)
   );

   always_comb begin
      if (is_arith)             result_o = sum;
      else if (op == OP_SCAN)   result_o = {{(DATA_W-IDX_W){1'b0}}, scan_idx};
      else                      result_o = logic_res;
   end

   assign carry_we_o = is_arith;
   assign carry_o    = is_arith ? cout : carry_i;
endmodule

// File: rtl/carry_alu_chk.sv
module carry_alu_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IMM_W  = 8
) (
   input logic [4:0]        op_i,
   input logic [DATA_W-1:0] src_a_i,
   input logic [DATA_W-1:0] src_b_i,
   input logic [IMM_W-1:0]  imm_i,
   input logic              imm_sel_i,
   input logic              carry_i,
   input logic [DATA_W-1:0] result_o,
   input logic              carry_o,
   input logic              carry_we_o
);
   logic [DATA_W-1:0] b_view;

   always_comb begin
      b_view = imm_sel_i ? DATA_W'(imm_i) : src_b_i;

      // R5: strobe only for the six add/subtract codes
      a_r5_strobe_family: assert (carry_we_o == (op_i <= 5'd5));
      // R5: carry passes through when not written
      a_r5_carry_hold: assert (carry_we_o || carry_o == carry_i);
      // R11: unused codes are silent
      a_r11_unused_zero: assert (op_i <= 5'd16 || (result_o == '0 && !carry_we_o));
      // R7: inversion depends on A only
      a_r7_inv: assert (op_i != 5'd11 || result_o == ~src_a_i);
      // R8: minimum is one of the operands and no larger than either
      a_r8_min: assert (op_i != 5'd12 ||
                        ((result_o == src_a_i || result_o == b_view) &&
                         result_o <= src_a_i && result_o <= b_view));
      // R8: maximum is one of the operands and no smaller than either
      a_r8_max: assert (op_i != 5'd13 ||
                        ((result_o == src_a_i || result_o == b_view) &&
                         result_o >= src_a_i && result_o >= b_view));
      // R10: scan result stays within 0..DATA_W
      a_r10_range: assert (op_i != 5'd16 || result_o <= DATA_W);
   end
endmodule

bind carry_alu carry_alu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
   .op_i       (op_i),
   .src_a_i    (src_a_i),
   .src_b_i    (src_b_i),
   .imm_i      (imm_i),
   .imm_sel_i  (imm_sel_i),
   .carry_i    (carry_i),
   .result_o   (result_o),
   .carry_o    (carry_o),
   .carry_we_o (carry_we_o)
);

// File: tb/tb_carry_alu.sv
module tb_carry_alu;
   localparam int W    = 8;
   localparam int IW   = 4;
   localparam int MODV = 1 << W;

   logic          clk = 1'b0;
   logic [4:0]    op;
   logic [W-1:0]  a, breg, res;
   logic [IW-1:0] imm;
   logic          isel, cin, cout, cwe;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   carry_alu #(.DATA_W(W), .IMM_W(IW)) dut (
      .op_i (op), .src_a_i (a), .src_b_i (breg), .imm_i (imm),
      .imm_sel_i (isel), .carry_i (cin),
      .result_o (res), .carry_o (cout), .carry_we_o (cwe)
   );

   // expected {we, carry, result}
   function automatic logic [W+1:0] model(int o, int ia, int ib, int c);
      int s, sh, r, cy, we, bitk;
      sh = ib % W;
      we = 0; cy = c; r = 0;
      case (o)
         0: begin s = ia + ib;     we = 1; cy = (s >= MODV); r = s % MODV; end
         1: begin s = ia + ib + c; we = 1; cy = (s >= MODV); r = s % MODV; end
         2: begin s = ia - ib;     we = 1; cy = (s < 0); r = (s + 2*MODV) % MODV; end
         3: begin s = ia - ib - c; we = 1; cy = (s < 0); r = (s + 2*MODV) % MODV; end
         4: begin s = ib - ia;     we = 1; cy = (s < 0); r = (s + 2*MODV) % MODV; end
         5: begin s = ib - ia - c; we = 1; cy = (s < 0); r = (s + 2*MODV) % MODV; end
         6: r = (ia * (1 << sh)) % MODV;
         7: r = ia / (1 << sh);
         8: r = ia & ib;
         9: r = ia | ib;
         10: r = ia ^ ib;
         11: r = MODV - 1 - ia;
         12: r = (ia < ib) ? ia : ib;
         13: r = (ia > ib) ? ia : ib;
         14: begin bitk = (ia / (1 << sh)) % 2; r = bitk ? ia - (1 << sh) : ia; end
         15: begin bitk = (ia / (1 << sh)) % 2; r = bitk ? ia : ia + (1 << sh); end
         16: begin
            r = W;
            for (int i = W - 1; i >= 0; i--) begin
               if (r == W && ((ia / (1 << i)) % 2) == (ib % 2)) r = i;
            end
         end
         default: r = 0;
      endcase
      return {we[0], cy[0], r[W-1:0]};
   endfunction

   function automatic string op_tag(int o);
      if (o <= 1)  return "R2";
      if (o <= 3)  return "R3";
      if (o <= 5)  return "R4";
      if (o <= 7)  return "R6";
      if (o <= 11) return "R7";
      if (o <= 13) return "R8";
      if (o <= 15) return "R9";
      if (o == 16) return "R10";
      return "R11";
   endfunction

   task automatic apply(int o, int ia, int ib, int iimm, int sel, int c);
      logic [W+1:0] exp;
      int           bop;
      string        tag;
      op = o[4:0]; a = ia[W-1:0]; breg = ib[W-1:0];
      imm = iimm[IW-1:0]; isel = sel[0]; cin = c[0];
      #1;
      bop = sel ? iimm : ib;
      exp = model(o, ia, bop, c);
      tag = sel ? {"R1/", op_tag(o)} : op_tag(o);
      n_chk++;
      if (res !== exp[W-1:0]) begin
         n_fail++;
         $display("FAIL %s result op=%0d a=%0h b=%0h c=%0d: got %0h exp %0h",
                  tag, o, ia, bop, c, res, exp[W-1:0]);
      end
      tag = (o <= 5) ? op_tag(o) : "R5";
      n_chk++;
      if (cwe !== exp[W+1] || cout !== exp[W]) begin
         n_fail++;
         $display("FAIL %s carry op=%0d a=%0h b=%0h c=%0d: got we=%0d c=%0d exp we=%0d c=%0d",
                  tag, o, ia, bop, c, cwe, cout, exp[W+1], exp[W]);
      end
      #1;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      // idle state: all inputs zero (R2 add of zeros)
      apply(0, 0, 0, 0, 0, 0);
      // used codes: sweep A fully, register operands spread, all immediates
      for (int o = 0; o <= 16; o++) begin
         for (int c = 0; c < 2; c++) begin
            for (int ia = 0; ia < MODV; ia++) begin
               for (int k = 0; k < 24; k++) begin
                  apply(o, ia, (k == 23) ? MODV - 1 : k * 11, 0, 0, c);
               end
               // R1: register operand holds junk that must not be used
               for (int im = 0; im < (1 << IW); im++) begin
                  apply(o, ia, (ia ^ 8'hA5) | 8'hF0, im, 1, c);
               end
            end
         end
      end
      // R11: unused codes with assorted operands
      for (int o = 17; o < 32; o++) begin
         for (int c = 0; c < 2; c++) begin
            for (int k = 0; k < 32; k++) begin
               apply(o, (k * 37 + 5) % MODV, (k * 53 + 1) % MODV, k % 16, k % 2, c);
            end
         end
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule